// File: doc/BRIEF.md
# Asynchronous HDLC Receive Frame Controller

This block sits behind a character receiver and builds frames out of the characters it delivers. A flag character `0x7E` marks frame edges. An escape character `0x7D` marks the next byte as transparent. Every frame ends in a 16-bit check sequence. Payload bytes go out on a single-byte write strobe. The block also drives buffer-descriptor open and close pulses, and each close carries a four-bit status word. Termination events are ranked: carrier loss comes first, then break, then abort, then a check-sequence mismatch.

The block also holds a write-one-to-clear event register with a mask and a level interrupt. Software clears events through a clear strobe and programs the mask through a separate strobe. Characters must arrive at least four clocks apart. All outputs are registered, so each pulse appears in the cycle after the character that caused it.

Top module: `ahdlc_rx_ctrl`

## Requirements
- R1: Bytes between two flags are written to the buffer in arrival order, in a frame of three or more bytes. An escape followed by a non-flag byte `b` yields `b ^ 0x20`. The two check-sequence bytes are held back. `desc_open` pulses in the same cycle as a descriptor's first `buf_wr`.
- R2: At a closing flag, the CRC-16 is checked: reflected polynomial `0x8408`, preset `0xFFFF`, computed over all received bytes. A residue of `0xF0B8` closes the descriptor with status `0000`. `frame_evt` pulses in the same cycle as every `desc_close`.
- R3: On a residue mismatch, the two received check bytes are written (low byte first) after the payload. The descriptor then closes with status bit 2 (CRC error) set.
- R4: Escape followed by flag inside a frame closes the descriptor with status bit 0 (abort) only, and no check-sequence bytes are written.
- R5: An abort, or the first break character, arriving while no descriptor is open raises `desc_open` and `desc_close` in the same cycle, with no `buf_wr`.
- R6: The first character flagged by `ch_break` closes the descriptor with status bit 1 (break). Further break characters are ignored until a non-break character arrives.
- R7: A low `carrier_ok` takes priority over everything else. An open descriptor closes with status bit 3 (carrier lost). Characters are ignored while carrier is low. After carrier returns, the block waits for a flag before accepting any data.
- R8: A frame of zero or one byte between flags produces no write, no open and no close.
- R9: After reset, `evt_q` is zero. Bit 3 is set by each `frame_evt` and bit 0 by each `buf_wr`. All other bits stay zero.
- R10: A clear write with a one clears that bit, and a zero leaves it unchanged. A new event in the same cycle wins over a clear.
- R11: `irq` is high exactly while some bit is set in both `evt_q` and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | 1 | Character strobe |
| ch_data | input | 8 | Received character |
| ch_break | input | 1 | Character is an all-zero break character |
| carrier_ok | input | 1 | Carrier-detect level, high when present |
| buf_wr | output | 1 | Data byte write strobe |
| buf_data | output | 8 | Data byte |
| desc_open | output | 1 | Descriptor open pulse |
| desc_close | output | 1 | Descriptor close pulse |
| desc_status | output | 4 | Close status: bit0 abort, bit1 break, bit2 CRC error, bit3 carrier lost |
| frame_evt | output | 1 | Frame-received pulse |
| ev_clr_wr | input | 1 | Event clear strobe |
| ev_clr_data | input | 16 | Ones select event bits to clear |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 16 | New mask value |
| evt_q | output | 16 | Event register |
| irq | output | 1 | Interrupt request |

## Verification
A payload containing both special bytes in escaped form checks that unescaping and the held-back check sequence work together. The same payload is then sent with a corrupted check sequence, which separates the good and bad close paths by the bytes written and the status bit. Aborts and breaks are sent both inside a frame and between frames, which shows the difference between closing an open descriptor and producing an empty one. Repeated break characters, back-to-back flags and one-byte frames show whether the block keeps state that it should discard. A carrier drop in the middle of a frame is followed by characters sent while carrier is low, to confirm that they are ignored and that the block resynchronises on the next flag.

// File: rtl/ahdlc_rx_pkg.sv
package ahdlc_rx_pkg;
   localparam int ST_W = 4;
   localparam logic [ST_W-1:0] STAT_NONE  = 4'b0000;
   localparam logic [ST_W-1:0] STAT_ABORT = 4'b0001;
   localparam logic [ST_W-1:0] STAT_BREAK = 4'b0010;
   localparam logic [ST_W-1:0] STAT_CRC   = 4'b0100;
   localparam logic [ST_W-1:0] STAT_NOCD  = 4'b1000;
   localparam int EV_RXB = 0;
   localparam int EV_RXF = 3;
   typedef enum logic [2:0] {S_HUNT, S_FRAME, S_FL1, S_FL2, S_NOCD} rx_state_t;
endpackage

// File: rtl/ahdlc_rx_crc.sv
module ahdlc_rx_crc #(
   parameter int          CRC_W    = 16,
   parameter int          BYTE_W   = 8,
   parameter logic [15:0] CRC_POLY = 16'h8408
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [CRC_W-1:0]  crc_out
);
   localparam int PAD_W = CRC_W - BYTE_W;

   always_comb begin
      logic [CRC_W-1:0] c;
      c = crc_in ^ {{PAD_W{1'b0}}, byte_in};
      for (int i = 0; i < BYTE_W; i++) begin
         c = c[0] ? ((c >> 1) ^ CRC_POLY[CRC_W-1:0]) : (c >> 1);
      end
      crc_out = c;
   end
endmodule

// File: rtl/ahdlc_rx_deframe.sv
module ahdlc_rx_deframe
   import ahdlc_rx_pkg::*;
#(
   parameter logic [7:0]  FLAG     = 8'h7E,
   parameter logic [7:0]  ESC      = 8'h7D,
   parameter logic [7:0]  ESC_XOR  = 8'h20,
   parameter logic [15:0] CRC_INIT = 16'hFFFF,
   parameter logic [15:0] CRC_POLY = 16'h8408,
   parameter logic [15:0] CRC_GOOD = 16'hF0B8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ch_valid,
   input  logic [7:0]      ch_data,
   input  logic            ch_break,
   input  logic            carrier_ok,
   output logic            buf_wr,
   output logic [7:0]      buf_data,
   output logic            desc_open,
   output logic            desc_close,
   output logic [ST_W-1:0] desc_status,
   output logic            frame_evt
);
   localparam logic [1:0] HOLD_FULL = 2'd2;

   rx_state_t   state_q;
   logic        esc_q, brk_q, opened_q;
   logic [1:0]  cnt_q;
   logic [7:0]  hold0_q, hold1_q;
   logic [15:0] crc_q, crc_nx;
   logic [7:0]  rx_byte;
   logic        take;

   assign rx_byte = esc_q ? (ch_data ^ ESC_XOR) : ch_data;

   ahdlc_rx_crc #(.CRC_W(16), .BYTE_W(8), .CRC_POLY(CRC_POLY)) crc_i (
      .crc_in(crc_q), .byte_in(rx_byte), .crc_out(crc_nx));

   // a data byte is accepted only inside a frame, with carrier, and when it is
   // neither a bare flag nor a bare escape
   always_comb begin
      take = 1'b0;
      if (carrier_ok && ch_valid && !ch_break && state_q == S_FRAME) begin
         if (esc_q) take = (ch_data != FLAG);
         else       take = (ch_data != FLAG) && (ch_data != ESC);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= S_HUNT;
         esc_q       <= 1'b0;
         brk_q       <= 1'b0;
         opened_q    <= 1'b0;
         cnt_q       <= '0;
         hold0_q     <= '0;
         hold1_q     <= '0;
         crc_q       <= CRC_INIT;
         buf_wr      <= 1'b0;
         buf_data    <= '0;
         desc_open   <= 1'b0;
         desc_close  <= 1'b0;
         desc_status <= STAT_NONE;
         frame_evt   <= 1'b0;
      end else begin
         buf_wr     <= 1'b0;
         desc_open  <= 1'b0;
         desc_close <= 1'b0;
         frame_evt  <= 1'b0;
         if (!carrier_ok && state_q != S_NOCD) begin
            if (opened_q) begin
               desc_close  <= 1'b1;
               frame_evt   <= 1'b1;
               desc_status <= STAT_NOCD;
               opened_q    <= 1'b0;
            end
            state_q <= S_NOCD;
            esc_q   <= 1'b0;
            brk_q   <= 1'b0;
            cnt_q   <= '0;
            crc_q   <= CRC_INIT;
         end else begin
            case (state_q)
               S_NOCD: if (carrier_ok) state_q <= S_HUNT;
               S_FL1: begin
                  buf_wr    <= 1'b1;
                  buf_data  <= hold1_q;
                  desc_open <= !opened_q;
                  opened_q  <= 1'b1;
                  state_q   <= S_FL2;
               end
               S_FL2: begin
                  buf_wr      <= 1'b1;
                  buf_data    <= hold0_q;
                  desc_close  <= 1'b1;
                  frame_evt   <= 1'b1;
                  desc_status <= STAT_CRC;
                  opened_q    <= 1'b0;
                  state_q     <= S_FRAME;
               end
               default: if (ch_valid) begin
                  if (ch_break) begin
                     if (!brk_q) begin
                        brk_q       <= 1'b1;
                        desc_open   <= !opened_q;
                        desc_close  <= 1'b1;
                        frame_evt   <= 1'b1;
                        desc_status <= STAT_BREAK;
                        opened_q    <= 1'b0;
                        state_q     <= S_HUNT;
                        esc_q       <= 1'b0;
                        cnt_q       <= '0;
                        crc_q       <= CRC_INIT;
                     end
                  end else begin
                     brk_q <= 1'b0;
                     if (esc_q) begin
                        esc_q <= 1'b0;
                        if (ch_data == FLAG) begin
                           desc_open   <= !opened_q;
                           desc_close  <= 1'b1;
                           frame_evt   <= 1'b1;
                           desc_status <= STAT_ABORT;
                           opened_q    <= 1'b0;
                           state_q     <= S_HUNT;
                           cnt_q       <= '0;
                           crc_q       <= CRC_INIT;
                        end
                     end else if (ch_data == ESC) begin
                        esc_q <= 1'b1;
                     end else if (ch_data == FLAG) begin
                        cnt_q   <= '0;
                        crc_q   <= CRC_INIT;
                        state_q <= S_FRAME;
                        if (state_q == S_FRAME && cnt_q == HOLD_FULL) begin
                           if (crc_q == CRC_GOOD) begin
                              desc_open   <= !opened_q;
                              desc_close  <= 1'b1;
                              frame_evt   <= 1'b1;
                              desc_status <= STAT_NONE;
                              opened_q    <= 1'b0;
                           end else begin
                              state_q <= S_FL1;
                           end
                        end
                     end
                  end
               end
            endcase
            if (take) begin
               crc_q   <= crc_nx;
               hold1_q <= hold0_q;
               hold0_q <= rx_byte;
               if (cnt_q == HOLD_FULL) begin
                  buf_wr    <= 1'b1;
                  buf_data  <= hold1_q;
                  desc_open <= !opened_q;
                  opened_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 2'd1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/ahdlc_rx_evreg.sv
module ahdlc_rx_evreg
   import ahdlc_rx_pkg::*;
#(
   parameter int EVT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_rxb,
   input  logic             set_rxf,
   input  logic             clr_wr,
   input  logic [EVT_W-1:0] clr_data,
   input  logic             mask_wr,
   input  logic [EVT_W-1:0] mask_data,
   output logic [EVT_W-1:0] evt_q,
   output logic             irq
);
   logic [EVT_W-1:0] set_vec, mask_q;

   always_comb begin
      set_vec         = '0;
      set_vec[EV_RXB] = set_rxb;
      set_vec[EV_RXF] = set_rxf;
   end

   for (genvar i = 0; i < EVT_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) evt_q[i] <= 1'b0;
         else        evt_q[i] <= set_vec[i] | (evt_q[i] & !(clr_wr & clr_data[i]));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= mask_data;
   end

   assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/ahdlc_rx_ctrl.sv
module ahdlc_rx_ctrl
   import ahdlc_rx_pkg::*;
#(
   parameter int          EVT_W    = 16,
   parameter logic [7:0]  FLAG     = 8'h7E,
   parameter logic [7:0]  ESC      = 8'h7D,
   parameter logic [7:0]  ESC_XOR  = 8'h20,
   parameter logic [15:0] CRC_INIT = 16'hFFFF,
   parameter logic [15:0] CRC_POLY = 16'h8408,
   parameter logic [15:0] CRC_GOOD = 16'hF0B8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ch_valid,
   input  logic [7:0]       ch_data,
   input  logic             ch_break,
   input  logic             carrier_ok,
   output logic             buf_wr,
   output logic [7:0]       buf_data,
   output logic             desc_open,
   output logic             desc_close,
   output logic [3:0]       desc_status,
   output logic             frame_evt,
   input  logic             ev_clr_wr,
   input  logic [EVT_W-1:0] ev_clr_data,
   input  logic             mask_wr,
   input  logic [EVT_W-1:0] mask_data,
   output logic [EVT_W-1:0] evt_q,
   output logic             irq
);
   if (EVT_W <= EV_RXF) begin : g_bad_width
      $error("EVT_W too small for the frame-received event bit");
   end
   if (FLAG == ESC) begin : g_bad_codes
      $error("flag and escape codes must differ");
   end

   ahdlc_rx_deframe #(
      .FLAG(FLAG), .ESC(ESC), .ESC_XOR(ESC_XOR),
      .CRC_INIT(CRC_INIT), .CRC_POLY(CRC_POLY), .CRC_GOOD(CRC_GOOD)
   ) deframe_i (
      .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
      .ch_break(ch_break), .carrier_ok(carrier_ok),
      .buf_wr(buf_wr), .buf_data(buf_data), .desc_open(desc_open),
      .desc_close(desc_close), .desc_status(desc_status), .frame_evt(frame_evt));

   ahdlc_rx_evreg #(.EVT_W(EVT_W)) evreg_i (
      .clk(clk), .rst_n(rst_n), .set_rxb(buf_wr), .set_rxf(frame_evt),
      .clr_wr(ev_clr_wr), .clr_data(ev_clr_data),
      .mask_wr(mask_wr), .mask_data(mask_data),
      .evt_q(evt_q), .irq(irq));
endmodule

// File: rtl/ahdlc_rx_ctrl_chk.sv
module ahdlc_rx_ctrl_chk
   import ahdlc_rx_pkg::*;
#(
   parameter int EVT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             carrier_ok,
   input logic             buf_wr,
   input logic             desc_open,
   input logic             desc_close,
   input logic [3:0]       desc_status,
   input logic             frame_evt,
   input logic             ev_clr_wr,
   input logic [EVT_W-1:0] ev_clr_data,
   input logic [EVT_W-1:0] evt_q,
   input logic             irq
);
   localparam logic [EVT_W-1:0] LIVE = EVT_W'((1 << EV_RXB) | (1 << EV_RXF));

   a_r1_open_with_first_write: assert property (@(posedge clk) disable iff (!rst_n)
      desc_open |-> (buf_wr || desc_close));

   a_r2_close_raises_event: assert property (@(posedge clk) disable iff (!rst_n)
      desc_close |-> frame_evt);

   a_r2_event_only_on_close: assert property (@(posedge clk) disable iff (!rst_n)
      frame_evt |-> desc_close);

   a_r4_status_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
      desc_close |-> $onehot0(desc_status));

   a_r7_no_write_without_carrier: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(carrier_ok) |-> !buf_wr);

   a_r9_reserved_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q & ~LIVE) == '0);

   a_r10_zero_write_keeps_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(evt_q[EV_RXF]) && !($past(ev_clr_wr) && $past(ev_clr_data[EV_RXF])))
      |-> evt_q[EV_RXF]);

   a_r11_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (evt_q != '0));
endmodule

bind ahdlc_rx_ctrl ahdlc_rx_ctrl_chk #(.EVT_W(EVT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .carrier_ok(carrier_ok), .buf_wr(buf_wr),
   .desc_open(desc_open), .desc_close(desc_close), .desc_status(desc_status),
   .frame_evt(frame_evt), .ev_clr_wr(ev_clr_wr), .ev_clr_data(ev_clr_data),
   .evt_q(evt_q), .irq(irq));

// File: tb/ahdlc_rx_ctrl_tb_top.sv
`timescale 1ns/1ps
module ahdlc_rx_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ch_valid = 1'b0, ch_break = 1'b0, carrier_ok = 1'b1;
   logic [7:0]  ch_data = '0;
   logic        buf_wr, desc_open, desc_close, frame_evt, irq;
   logic [7:0]  buf_data;
   logic [3:0]  desc_status;
   logic        ev_clr_wr = 1'b0, mask_wr = 1'b0;
   logic [15:0] ev_clr_data = '0, mask_data = '0, evt_q;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ahdlc_rx_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
      .ch_break(ch_break), .carrier_ok(carrier_ok), .buf_wr(buf_wr),
      .buf_data(buf_data), .desc_open(desc_open), .desc_close(desc_close),
      .desc_status(desc_status), .frame_evt(frame_evt), .ev_clr_wr(ev_clr_wr),
      .ev_clr_data(ev_clr_data), .mask_wr(mask_wr), .mask_data(mask_data),
      .evt_q(evt_q), .irq(irq));

   // output log, sampled at falling edges
   logic [7:0] wlog [0:63];
   int nw, nopen, nclose, nempty, nopen_w;
   logic [3:0] last_st;

   always @(negedge clk) begin
      if (rst_n) begin
         if (buf_wr && nw < 64) begin wlog[nw] = buf_data; nw++; end
         if (desc_open) nopen++;
         if (desc_open && buf_wr) nopen_w++;
         if (desc_close) begin
            nclose++;
            last_st = desc_status;
            if (desc_open) nempty++;
         end
      end
   end

   task automatic clear_log();
      nw = 0; nopen = 0; nclose = 0; nempty = 0; nopen_w = 0; last_st = 4'hx;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {8'h00, b};
      for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
      return r;
   endfunction

   task automatic send_raw(input logic [7:0] b);
      @(negedge clk);
      ch_valid = 1'b1; ch_data = b; ch_break = 1'b0;
      @(negedge clk);
      ch_valid = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_brk();
      @(negedge clk);
      ch_valid = 1'b1; ch_data = 8'h00; ch_break = 1'b1;
      @(negedge clk);
      ch_valid = 1'b0; ch_break = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_data(input logic [7:0] b);
      if (b == 8'h7E || b == 8'h7D) begin
         send_raw(8'h7D);
         send_raw(b ^ 8'h20);
      end else send_raw(b);
   endtask

   // sends a complete frame; bad=1 corrupts the check sequence
   task automatic send_frame(input logic [7:0] p [8], input int n, input bit bad,
                             output logic [7:0] fcs_lo, output logic [7:0] fcs_hi);
      logic [15:0] c;
      c = 16'hFFFF;
      send_raw(8'h7E);
      for (int i = 0; i < n; i++) begin
         c = crc_byte(c, p[i]);
         send_data(p[i]);
      end
      c = ~c;
      if (bad) c = c ^ 16'h0001;
      fcs_lo = c[7:0]; fcs_hi = c[15:8];
      send_data(fcs_lo);
      send_data(fcs_hi);
      send_raw(8'h7E);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!buf_wr && !desc_open && !desc_close && !frame_evt, "R9 reset pulses", buf_wr, 0);
      chk(evt_q == 16'h0, "R9 reset evt_q", evt_q, 0);
      chk(!irq, "R11 reset irq", irq, 0);
   endtask

   task automatic t_good();
      logic [7:0] p [8];
      logic [7:0] lo, hi;
      p = '{8'h11, 8'h7E, 8'h7D, 8'h22, 8'h03, 8'h00, 8'h00, 8'h00};
      clear_log();
      send_frame(p, 5, 1'b0, lo, hi);
      chk(nw == 5, "R1 write count", nw, 5);
      for (int i = 0; i < 5; i++)
         chk(wlog[i] == p[i], "R1 unescaped byte", wlog[i], p[i]);
      chk(nopen == 1 && nopen_w == 1, "R1 open with first write", nopen_w, 1);
      chk(nclose == 1 && last_st == 4'b0000, "R2 good close status", last_st, 0);
   endtask

   task automatic t_bad();
      logic [7:0] p [8];
      logic [7:0] lo, hi;
      p = '{8'hA5, 8'h7D, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      clear_log();
      send_frame(p, 3, 1'b1, lo, hi);
      chk(nw == 5, "R3 write count", nw, 5);
      chk(wlog[2] == p[2], "R3 payload end", wlog[2], p[2]);
      chk(wlog[3] == lo, "R3 fcs low byte", wlog[3], lo);
      chk(wlog[4] == hi, "R3 fcs high byte", wlog[4], hi);
      chk(nclose == 1 && last_st == 4'b0100, "R3 crc status", last_st, 4'b0100);
   endtask

   task automatic t_short();
      clear_log();
      send_raw(8'h7E); send_raw(8'h7E); send_raw(8'h7E);
      send_raw(8'h44); send_raw(8'h7E);
      repeat (4) @(negedge clk);
      chk(nw == 0 && nopen == 0 && nclose == 0, "R8 short frames silent", nw + nopen + nclose, 0);
   endtask

   task automatic t_abort_frame();
      clear_log();
      send_raw(8'h7E);
      send_raw(8'h31); send_raw(8'h32); send_raw(8'h33); send_raw(8'h34);
      send_raw(8'h7D); send_raw(8'h7E);
      repeat (4) @(negedge clk);
      chk(nw == 2 && wlog[0] == 8'h31 && wlog[1] == 8'h32, "R4 bytes before abort", nw, 2);
      chk(nclose == 1 && last_st == 4'b0001, "R4 abort status", last_st, 1);
      chk(nempty == 0, "R4 descriptor was already open", nempty, 0);
   endtask

   task automatic t_abort_idle();
      clear_log();
      send_raw(8'h7D); send_raw(8'h7E);
      repeat (4) @(negedge clk);
      chk(nempty == 1 && nclose == 1 && nw == 0, "R5 idle abort empty desc", nempty, 1);
      chk(last_st == 4'b0001, "R5 idle abort status", last_st, 1);
   endtask

   task automatic t_break();
      clear_log();
      send_raw(8'h7E);
      send_raw(8'h41); send_raw(8'h42); send_raw(8'h43);
      send_brk(); send_brk(); send_brk();
      repeat (4) @(negedge clk);
      chk(nw == 1 && wlog[0] == 8'h41, "R6 bytes before break", nw, 1);
      chk(nclose == 1 && last_st == 4'b0010, "R6 single break close", nclose, 1);
      clear_log();
      send_raw(8'h55);
      send_brk();
      repeat (4) @(negedge clk);
      chk(nempty == 1 && nclose == 1 && last_st == 4'b0010, "R5 idle break empty desc", nempty, 1);
   endtask

   task automatic t_carrier();
      logic [7:0] p [8];
      logic [7:0] lo, hi;
      clear_log();
      send_raw(8'h7E);
      send_raw(8'h61); send_raw(8'h62); send_raw(8'h63); send_raw(8'h64);
      @(negedge clk); carrier_ok = 1'b0;
      repeat (4) @(negedge clk);
      chk(nclose == 1 && last_st == 4'b1000, "R7 carrier-lost close", last_st, 4'b1000);
      clear_log();
      send_raw(8'h7E); send_raw(8'h71); send_raw(8'h72); send_raw(8'h73); send_raw(8'h7E);
      chk(nw == 0 && nclose == 0 && nopen == 0, "R7 ignored while carrier low", nw + nclose, 0);
      @(negedge clk); carrier_ok = 1'b1;
      repeat (4) @(negedge clk);
      send_raw(8'h81); send_raw(8'h82); send_raw(8'h83); send_raw(8'h84);
      chk(nw == 0, "R7 waits for flag after carrier", nw, 0);
      p = '{8'h91, 8'h92, 8'h93, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      clear_log();
      send_frame(p, 3, 1'b0, lo, hi);
      chk(nw == 3 && wlog[0] == 8'h91 && nclose == 1 && last_st == 4'b0000,
          "R7 resync frame good", nw, 3);
   endtask

   task automatic ev_clear(input logic [15:0] v);
      @(negedge clk); ev_clr_wr = 1'b1; ev_clr_data = v;
      @(negedge clk); ev_clr_wr = 1'b0; ev_clr_data = '0;
   endtask

   task automatic t_events();
      logic [7:0] p [8];
      logic [7:0] lo, hi;
      ev_clear(16'hFFFF);
      chk(evt_q == 16'h0, "R10 clear all", evt_q, 0);
      p = '{8'hC1, 8'hC2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      send_frame(p, 2, 1'b0, lo, hi);
      chk(evt_q == 16'h0009, "R9 rxb and rxf set", evt_q, 16'h0009);
      chk(!irq, "R11 masked irq low", irq, 0);
      @(negedge clk); mask_wr = 1'b1; mask_data = 16'h0008;
      @(negedge clk); mask_wr = 1'b0;
      chk(irq, "R11 unmasked irq high", irq, 1);
      ev_clear(16'h0000);
      chk(evt_q == 16'h0009, "R10 zero write no effect", evt_q, 16'h0009);
      ev_clear(16'h0001);
      chk(evt_q == 16'h0008 && irq, "R10 clear bit0 keeps irq", evt_q, 16'h0008);
      ev_clear(16'h0008);
      chk(evt_q == 16'h0 && !irq, "R11 irq drops after clear", evt_q, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      clear_log();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_good();
      t_bad();
      t_short();
      t_abort_frame();
      t_abort_idle();
      t_break();
      t_carrier();
      t_events();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule